// File: doc/BRIEF.md
# Serial EEPROM Slave Command Interface

This block is the digital front end of a 256-word by 16-bit serial non-volatile memory, rebuilt as synchronous logic that runs on a single system clock. A host talks to it over three wires: an active-low select, a serial clock and a data input. The block answers on a data output that it drives only when it has something to say, and it gives an output enable alongside that data output. A separate ready output goes low while a write is being committed. An active-high write-abort input inhibits a write, or cuts one short. The word store is an internal register array.

The select, serial clock, data and abort pins each pass through a two-stage synchronizer. Edges on select and serial clock are found by comparing the synchronized level with the sample taken one system clock earlier. The serial clock level at the moment select falls picks the kind of frame. With the clock high, the frame carries an instruction. With the clock low, the block enters a status mode and reports ready or busy on the data output. A read streams words for as long as the host keeps clocking, and the word address wraps from 0xFF back to 0x00. A write becomes a timed busy period of `BUSY_CYC` system clocks, and the word is stored when that period ends.

Top module: `sermem_front`

## Requirements
- R1: A frame is sampled on rising serial clock edges, most significant bit first. It holds an 8-bit op-code, then an 8-bit word address, and for a write a further 16 data bits. The op-codes are 0xA8 for read, 0xA4 for write, 0xA3 for write-enable and 0xA0 for write-disable.
- R2: If select falls while the serial clock is high, the block takes an instruction. If select falls while the serial clock is low, the block enters status mode, raises `sdo_oe` and drives `sdo` equal to `ready`.
- R3: Status mode ends when select rises, or at a rising serial clock edge with `sdi` high. In the second case that 1 counts as the first op-code bit of a new instruction.
- R4: At the 32nd rising edge of an enabled write, with abort low, `ready` falls for exactly `BUSY_CYC` system clocks. The word is stored when `ready` returns high.
- R5: An instruction frame that begins while `ready` is low is ignored in full, up to the next rise of select.
- R6: After the 16th rising edge of a read frame, each falling serial clock edge drives the next bit on `sdo`, starting with bit 15 of the addressed word. After bit 0 the block continues with the next address, and 0xFF is followed by 0x00.
- R7: After reset the block is write-disabled. Write-enable sets the enable and write-disable clears it, each at the 16th rising edge of its frame. A write while disabled changes nothing. Reads work in either state.
- R8: If `wr_abort` is high at the 32nd rising edge, the write is inhibited. If `wr_abort` goes high during the busy period, busy ends one system clock after the synchronized abort is seen, and the word is set to 0xFFFF.
- R9: A rise of select ends any frame and drops `sdo_oe`. `sdo_oe` is high only during read data or status mode.
- R10: A frame with any op-code other than the four listed in R1 is ignored until select rises.
- R11: A pin change made between two system clock edges first shows at the outputs after the third following edge, because of two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cs_n | input | 1 | Active-low select from host |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| wr_abort | input | 1 | Active-high write inhibit and abort |
| sdo | output | 1 | Serial data or status to host |
| sdo_oe | output | 1 | High while `sdo` is driven; low means high impedance |
| ready | output | 1 | High when idle, low during a write commit |

## Verification
Two functions can land in the same system clock: the busy timer counting down, and a host frame or abort arriving. The bench opens a status frame while a commit is running. Still inside that busy period it starts an instruction frame, then raises the abort pin part-way through a second commit. A behavioural model written with plain integers predicts `ready`, `sdo_oe` and `sdo` on every clock. The bench then compares each word read back against constants taken from the requirements.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    localparam int OP_BITS = 8;

    localparam logic [OP_BITS-1:0] OPC_READ  = 8'hA8;
    localparam logic [OP_BITS-1:0] OPC_WRITE = 8'hA4;
    localparam logic [OP_BITS-1:0] OPC_WEN   = 8'hA3;
    localparam logic [OP_BITS-1:0] OPC_WDIS  = 8'hA0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAT,
        ST_RECV,
        ST_READ,
        ST_SKIP
    } fsm_e;

    function automatic logic op_known(input logic [OP_BITS-1:0] op);
        return (op == OPC_READ) || (op == OPC_WRITE) ||
               (op == OPC_WEN)  || (op == OPC_WDIS);
    endfunction

endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] stg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= {2{RST_VAL[g]}};
            else        stg_q <= {stg_q[0], d[g]};
        end
        assign q[g] = stg_q[1];
    end

endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sermem_front.sv
module sermem_front
    import sermem_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int BUSY_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    input  logic wr_abort,
    output logic sdo,
    output logic sdo_oe,
    output logic ready
);

    localparam int HDR_BITS = OP_BITS + ADDR_W;
    localparam int FRAME_W  = HDR_BITS + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int TMR_W    = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        fsm_e              st;
        logic [CNT_W-1:0]  cnt;
        logic [FRAME_W-1:0] sh;
        logic              cs_p;
        logic              sk_p;
        logic              wen;
        logic              busy;
        logic [TMR_W-1:0]  tmr;
        logic [ADDR_W-1:0] baddr;
        logic [DATA_W-1:0] bdata;
        logic [ADDR_W-1:0] raddr;
        logic [BIT_W-1:0]  rbit;
        logic              dout;
        logic              doe;
    } state_t;

    state_t s_d, s_q;

    logic [3:0]        pins_s;
    logic              cs_s, sk_s, sdi_s, abort_s;
    logic              cs_rise, cs_fall, sk_rise, sk_fall;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic [FRAME_W-1:0] nsh;

    sermem_sync #(.W(4), .RST_VAL(4'b0001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wr_abort, sdi, sclk, cs_n}),
        .q     (pins_s)
    );

    assign cs_s    = pins_s[0];
    assign sk_s    = pins_s[1];
    assign sdi_s   = pins_s[2];
    assign abort_s = pins_s[3];

    assign cs_rise = ~s_q.cs_p & cs_s;
    assign cs_fall = s_q.cs_p & ~cs_s;
    assign sk_rise = ~s_q.sk_p & sk_s;
    assign sk_fall = s_q.sk_p & ~sk_s;

    sermem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (s_q.baddr),
        .wdata (mem_wdata),
        .raddr (s_q.raddr),
        .rdata (mem_rdata)
    );

    always_comb begin
        s_d       = s_q;
        s_d.cs_p  = cs_s;
        s_d.sk_p  = sk_s;
        mem_we    = 1'b0;
        mem_wdata = s_q.bdata;
        nsh       = {s_q.sh[FRAME_W-2:0], sdi_s};

        // commit timer: abort corrupts the word and frees the block
        if (s_q.busy) begin
            if (abort_s) begin
                mem_we    = 1'b1;
                mem_wdata = '1;
                s_d.busy  = 1'b0;
            end else if (s_q.tmr == '0) begin
                mem_we   = 1'b1;
                s_d.busy = 1'b0;
            end else begin
                s_d.tmr = s_q.tmr - 1'b1;
            end
        end

        if (cs_rise) begin
            s_d.st  = ST_IDLE;
            s_d.doe = 1'b0;
        end else if (cs_fall) begin
            s_d.cnt = '0;
            s_d.sh  = '0;
            if (!sk_s) begin
                s_d.st  = ST_STAT;
                s_d.doe = 1'b1;
            end else begin
                s_d.doe = 1'b0;
                s_d.st  = s_q.busy ? ST_SKIP : ST_RECV;
            end
        end else begin
            case (s_q.st)
                ST_STAT: begin
                    if (sk_rise && sdi_s) begin
                        s_d.doe = 1'b0;
                        s_d.sh  = nsh;
                        s_d.cnt = CNT_W'(1);
                        s_d.st  = s_q.busy ? ST_SKIP : ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (sk_rise) begin
                        s_d.sh  = nsh;
                        s_d.cnt = s_q.cnt + 1'b1;
                        if (s_q.cnt == CNT_W'(OP_BITS - 1)) begin
                            if (!op_known(nsh[OP_BITS-1:0])) s_d.st = ST_SKIP;
                        end else if (s_q.cnt == CNT_W'(HDR_BITS - 1)) begin
                            case (nsh[ADDR_W +: OP_BITS])
                                OPC_READ: begin
                                    s_d.st    = ST_READ;
                                    s_d.raddr = nsh[ADDR_W-1:0];
                                    s_d.rbit  = BIT_W'(DATA_W - 1);
                                end
                                OPC_WEN: begin
                                    s_d.wen = 1'b1;
                                    s_d.st  = ST_SKIP;
                                end
                                OPC_WDIS: begin
                                    s_d.wen = 1'b0;
                                    s_d.st  = ST_SKIP;
                                end
                                default: ;
                            endcase
                        end else if (s_q.cnt == CNT_W'(FRAME_W - 1)) begin
                            s_d.st = ST_SKIP;
                            if (nsh[FRAME_W-1 -: OP_BITS] == OPC_WRITE &&
                                s_q.wen && !abort_s && !s_q.busy) begin
                                s_d.busy  = 1'b1;
                                s_d.tmr   = TMR_W'(BUSY_CYC - 1);
                                s_d.baddr = nsh[DATA_W +: ADDR_W];
                                s_d.bdata = nsh[DATA_W-1:0];
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (sk_fall) begin
                        s_d.dout = mem_rdata[s_q.rbit];
                        s_d.doe  = 1'b1;
                        if (s_q.rbit == '0) begin
                            s_d.rbit  = BIT_W'(DATA_W - 1);
                            s_d.raddr = s_q.raddr + 1'b1;
                        end else begin
                            s_d.rbit = s_q.rbit - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.cs_p  <= 1'b1;
            s_q.rbit  <= BIT_W'(DATA_W - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo    = (s_q.st == ST_STAT) ? ~s_q.busy : s_q.dout;
    assign sdo_oe = s_q.doe;
    assign ready  = ~s_q.busy;

    a_r2_status_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && !sk_s) |=> (sdo_oe && s_q.st == ST_STAT))
        else $error("R2: status mode not entered");

    a_r4_busy_from_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> ($past(s_q.st) == ST_RECV &&
                             $past(s_q.cnt) == CNT_W'(FRAME_W - 1)))
        else $error("R4: busy began outside a frame end");

    a_r5_refuse_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && sk_s && s_q.busy) |=> (s_q.st == ST_SKIP))
        else $error("R5: frame accepted while busy");

    a_r6_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_READ && !sk_fall && !cs_rise && !cs_fall) |=> $stable(sdo))
        else $error("R6: read data moved without a falling edge");

    a_r7_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> $past(s_q.wen))
        else $error("R7: write committed while disabled");

    a_r8_abort_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && abort_s) |=> ready)
        else $error("R8: abort did not free the block");

    a_r9_cs_rise_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdo_oe)
        else $error("R9: output still driven after deselect");

endmodule

// File: tb/sim_sermem_front.sv
module sim_sermem_front;

    localparam int CLK_P = 10;
    localparam int HALF  = 4;
    localparam int BUSY  = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0, wr_abort = 1'b0;
    logic sdo, sdo_oe, ready;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sermem_front #(.ADDR_W(8), .DATA_W(16), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .wr_abort(wr_abort), .sdo(sdo), .sdo_oe(sdo_oe), .ready(ready)
    );

    // ---------------- behavioural reference model ----------------
    int   m_mode;          // 0 idle, 1 status, 2 receive, 3 read, 4 skip
    int   m_bits, m_tmr, m_baddr, m_bdata, m_raddr, m_rbit;
    bit   m_wen, m_busy, m_dout, m_doe;
    logic [31:0] m_frame;
    int   m_mem [256];
    logic [3:0] hist1, hist2;      // {abort, sdi, sclk, cs_n}
    logic last_cs, last_sk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_bits = 0; m_tmr = 0; m_baddr = 0; m_bdata = 0;
            m_raddr = 0; m_rbit = 15; m_wen = 0; m_busy = 0; m_dout = 0;
            m_doe = 0; m_frame = 0;
            foreach (m_mem[i]) m_mem[i] = 0;
            hist1 = 4'b0001; hist2 = 4'b0001; last_cs = 1'b1; last_sk = 1'b0;
        end else begin
            logic c, k, d, ab;
            bit   was_busy;
            logic [31:0] nf;
            c = hist2[0]; k = hist2[1]; d = hist2[2]; ab = hist2[3];
            was_busy = m_busy;
            nf = {m_frame[30:0], d};
            if (was_busy) begin
                if (ab) begin m_mem[m_baddr] = 16'hFFFF; m_busy = 0; end
                else if (m_tmr == 0) begin m_mem[m_baddr] = m_bdata; m_busy = 0; end
                else m_tmr--;
            end
            if (!last_cs && c) begin
                m_mode = 0; m_doe = 0;
            end else if (last_cs && !c) begin
                m_bits = 0; m_frame = 0;
                if (!k) begin m_mode = 1; m_doe = 1; end
                else begin m_doe = 0; m_mode = was_busy ? 4 : 2; end
            end else if (m_mode == 1) begin
                if (!last_sk && k && d) begin
                    m_doe = 0; m_frame = nf; m_bits = 1;
                    m_mode = was_busy ? 4 : 2;
                end
            end else if (m_mode == 2) begin
                if (!last_sk && k) begin
                    m_frame = nf; m_bits++;
                    if (m_bits == 8) begin
                        if (!(nf[7:0] inside {8'hA8, 8'hA4, 8'hA3, 8'hA0})) m_mode = 4;
                    end else if (m_bits == 16) begin
                        if (nf[15:8] == 8'hA8) begin
                            m_mode = 3; m_raddr = nf[7:0]; m_rbit = 15;
                        end else if (nf[15:8] == 8'hA3) begin m_wen = 1; m_mode = 4; end
                        else if (nf[15:8] == 8'hA0) begin m_wen = 0; m_mode = 4; end
                    end else if (m_bits == 32) begin
                        m_mode = 4;
                        if (m_wen && !ab) begin
                            m_busy = 1; m_tmr = BUSY - 1;
                            m_baddr = nf[23:16]; m_bdata = nf[15:0];
                        end
                    end
                end
            end else if (m_mode == 3) begin
                if (last_sk && !k) begin
                    m_dout = (m_mem[m_raddr] >> m_rbit) & 1;
                    m_doe = 1;
                    if (m_rbit == 0) begin m_rbit = 15; m_raddr = (m_raddr + 1) % 256; end
                    else m_rbit--;
                end
            end
            last_cs = c; last_sk = k;
            hist2 = hist1;
            hist1 = {wr_abort, sdi, sclk, cs_n};
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_sdo;
            exp_sdo = (m_mode == 1) ? !m_busy : m_dout;
            vectors++;
            if (ready !== !m_busy) begin
                fails++; $display("FAIL R4 ready act=%b exp=%b t=%0t", ready, !m_busy, $time);
            end
            if (sdo_oe !== m_doe) begin
                fails++; $display("FAIL R9 sdo_oe act=%b exp=%b t=%0t", sdo_oe, m_doe, $time);
            end
            if (m_doe && sdo !== exp_sdo) begin
                fails++; $display("FAIL R6 sdo act=%b exp=%b t=%0t", sdo, exp_sdo, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic open_frame(input logic sk_level);
        sclk = sk_level; tick(HALF);
        cs_n = 1'b0;     tick(HALF);
    endtask

    task automatic close_frame();
        cs_n = 1'b1; sclk = 1'b1; tick(2 * HALF);
    endtask

    task automatic shift_out(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0; sdi = v[i]; tick(HALF);
            sclk = 1'b1; tick(HALF);
        end
    endtask

    task automatic take_word(output logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            sclk = 1'b0; tick(HALF);
            w[i] = sdo;
            sclk = 1'b1; tick(HALF);
        end
    endtask

    task automatic short_cmd(input logic [7:0] op);
        open_frame(1'b1); shift_out({op, 8'h00}, 16); close_frame();
    endtask

    task automatic write_word(input logic [7:0] a, input logic [15:0] d);
        open_frame(1'b1); shift_out({8'hA4, a, d}, 32); close_frame();
    endtask

    task automatic read_one(input logic [7:0] a, output logic [15:0] w);
        open_frame(1'b1); shift_out({8'hA8, a}, 16); take_word(w); close_frame();
    endtask

    task automatic wait_ready();
        for (int n = 0; n < 5000 && !ready; n++) tick(1);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [15:0] w;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check("R4 reset ready", ready, 1);
        check("R9 reset oe", sdo_oe, 0);

        // R11 latency and R2 status while idle
        sclk = 1'b0; tick(HALF);
        cs_n = 1'b0; tick(2);
        check("R11 oe before third edge", sdo_oe, 0);
        tick(1);
        check("R11 oe at third edge", sdo_oe, 1);
        check("R2 status shows ready", sdo, 1);
        close_frame();

        read_one(8'h00, w);
        check("R6 blank word", w, 16'h0000);

        // R7 write while disabled
        write_word(8'h12, 16'hA5C3);
        check("R7 no busy when disabled", ready, 1);
        read_one(8'h12, w);
        check("R7 disabled write dropped", w, 16'h0000);

        // R1 / R4 enabled write
        short_cmd(8'hA3);
        write_word(8'h12, 16'hA5C3);
        check("R4 busy after write", ready, 0);

        // R2 status during busy
        open_frame(1'b0);
        check("R2 status driven", sdo_oe, 1);
        check("R2 status shows busy", sdo, 0);
        close_frame();

        // R5 frame during busy is ignored
        write_word(8'h34, 16'hBEEF);
        wait_ready();
        check("R4 ready again", ready, 1);

        // R3 status then instruction from first 1 bit
        open_frame(1'b0);
        check("R3 status before opcode", sdo, 1);
        shift_out({8'hA8, 8'h12}, 16);
        take_word(w);
        close_frame();
        check("R3 read after status", w, 16'hA5C3);
        check("R1 frame format", w, 16'hA5C3);

        read_one(8'h34, w);
        check("R5 busy frame ignored", w, 16'h0000);

        // R6 streaming with wrap
        write_word(8'hFF, 16'h1357); wait_ready();
        write_word(8'h00, 16'h2468); wait_ready();
        open_frame(1'b1);
        shift_out({8'hA8, 8'hFE}, 16);
        take_word(w); check("R6 stream word FE", w, 16'h0000);
        take_word(w); check("R6 stream word FF", w, 16'h1357);
        take_word(w); check("R6 wrap to 00", w, 16'h2468);
        take_word(w); check("R6 stream word 01", w, 16'h0000);
        close_frame();

        // R8 inhibit at start
        wr_abort = 1'b1;
        write_word(8'h40, 16'h9999);
        check("R8 inhibited no busy", ready, 1);
        wr_abort = 1'b0;
        tick(4);
        read_one(8'h40, w);
        check("R8 inhibited word", w, 16'h0000);

        // R8 abort mid busy
        write_word(8'h41, 16'h7777);
        tick(20);
        check("R8 busy before abort", ready, 0);
        wr_abort = 1'b1; tick(4);
        check("R8 abort frees block", ready, 1);
        wr_abort = 1'b0; tick(4);
        read_one(8'h41, w);
        check("R8 corrupt pattern", w, 16'hFFFF);

        // R10 unknown op-code
        write_word(8'h50, 16'h5555);
        wait_ready();
        open_frame(1'b1);
        shift_out({8'hA1, 8'h50, 16'h0F0F}, 32);
        check("R10 no output on bad op", sdo_oe, 0);
        close_frame();
        check("R10 no busy on bad op", ready, 1);
        read_one(8'h50, w);
        check("R10 word untouched", w, 16'h5555);

        // R9 deselect mid write
        open_frame(1'b1);
        shift_out({8'hA4, 8'h60, 8'hAB}, 24);
        close_frame();
        check("R9 aborted frame no busy", ready, 1);
        read_one(8'h60, w);
        check("R9 aborted frame word", w, 16'h0000);

        // R7 write-disable, read still works
        short_cmd(8'hA0);
        write_word(8'h42, 16'h1111);
        check("R7 disabled again no busy", ready, 1);
        read_one(8'h42, w);
        check("R7 disabled write dropped again", w, 16'h0000);
        read_one(8'h12, w);
        check("R7 read while disabled", w, 16'hA5C3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule